// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Block

This block turns a bank of logic inputs into a row of output cells, and configuration decides the logic between them. Each input is offered to a programmable AND plane as two literals, its true value and its complement. Every product term in a shared pool ANDs any chosen subset of those literals. An allocator then hands out the terms to the output cells. A cell ORs the terms it receives, can invert the sum, and can pass it straight through or through a flip-flop clocked by the global clock. Each cell also drives an output-enable, chosen per cell from off, on, the global output-enable or its inverse.

A single address/data port with a write strobe loads the configuration. The pool is not split among the cells ahead of time. Any cell may take any number of terms, up to the whole pool. When more than one cell claims the same term, an error output goes high and the lowest-numbered claimant keeps the term. The global set/reset clears the cell flip-flops and all configuration at once.

Top module: `sop_block`

## Requirements
- R1: Literal 2i of a term's mask selects input i true and literal 2i+1 selects input i complemented. A term is the AND of its selected literals, so a term that selects both polarities of one input is always 0.
- R2: A product term with no literal selected evaluates to 1.
- R3: A cell's sum is the OR of the terms granted to it, and a cell with no granted terms has a sum of 0.
- R4: A single cell can be granted every term in the pool, up to the last term index.
- R5: If a term is claimed by two or more cells, cfg_err is 1 and only the lowest-numbered claimant receives that term. When no term is claimed twice, cfg_err is 0.
- R6: Mode bit 1 set inverts the cell's sum before it reaches the output.
- R7: With mode bit 0 set, dout shows the cell value captured at the most recent rising clock edge. With mode bit 0 clear, dout follows the inputs combinationally.
- R8: Asserting gsr immediately clears every cell flip-flop and all configuration, without waiting for a clock edge.
- R9: Mode bits [3:2] select the output-enable: 0 gives off, 1 gives on, 2 follows goe, 3 follows the inverse of goe.
- R10: cfg_addr splits into region [10:9], index [8:2] and word [1:0]. Region 0 holds the literal masks of the terms, in three 36-bit words with word 0 lowest. Region 1 holds the cell claim masks, also in three words. Region 2 holds the 4-bit mode of a cell in data bits [3:0]. A write takes effect at the rising edge that samples cfg_we.
- R11: Writes to region 3, or to an index or word beyond the configured range, change nothing.
- R12: After reset, every dout and doe is 0 and cfg_err is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for the cell flip-flops and the configuration store |
| gsr | input | 1 | Global asynchronous set/reset, active high |
| goe | input | 1 | Global output-enable |
| din | input | 54 | Logic inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 11 | Configuration address: region, index, word |
| cfg_wdata | input | 36 | Configuration write data |
| dout | output | 18 | One output per cell |
| doe | output | 18 | One output-enable per cell |
| cfg_err | output | 1 | A product term is claimed by more than one cell |

## Verification
On every cycle, the assertions check that no term is granted to two cells at once. They also check that every claim is honoured when cfg_err is low, and that a registered cell shows the value from the previous edge. Two more checks cover output-enables, which never rise while the mode says off, and mode writes, which land in the addressed cell. Only the bench scenarios can show the logic function itself: the literal polarity, empty terms, a cell holding the whole pool, which cell wins a contested term, and that writes out of range leave the outputs untouched.

// File: rtl/sop_pkg.sv
package sop_pkg;

  typedef enum logic [1:0] {
    OE_OFF      = 2'd0,
    OE_ON       = 2'd1,
    OE_GLOBAL   = 2'd2,
    OE_GLOBAL_N = 2'd3
  } oe_sel_e;

  typedef enum logic [1:0] {
    RG_TERM  = 2'd0,
    RG_CLAIM = 2'd1,
    RG_MODE  = 2'd2,
    RG_NONE  = 2'd3
  } cfg_region_e;

  typedef struct packed {
    oe_sel_e oe;
    logic    invert;
    logic    registered;
  } cell_mode_t;

  function automatic int ceil_div(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int word_bits(int n_in, int n_pt, int dw);
    int m;
    m = ceil_div(2 * n_in, dw);
    if (ceil_div(n_pt, dw) > m) m = ceil_div(n_pt, dw);
    return (m <= 1) ? 1 : $clog2(m);
  endfunction

  function automatic int idx_bits(int n_pt, int n_cell);
    int m;
    m = (n_pt > n_cell) ? n_pt : n_cell;
    return (m <= 1) ? 1 : $clog2(m);
  endfunction

  function automatic logic oe_value(oe_sel_e s, logic goe);
    case (s)
      OE_ON:       return 1'b1;
      OE_GLOBAL:   return goe;
      OE_GLOBAL_N: return ~goe;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store
  import sop_pkg::*;
#(
  parameter int N_IN   = 54,
  parameter int N_PT   = 90,
  parameter int N_CELL = 18,
  parameter int DW     = 36,
  parameter int IDX_W  = 7,
  parameter int WORD_W = 2,
  localparam int LIT_W       = 2 * N_IN,
  localparam int ADDR_W      = 2 + IDX_W + WORD_W,
  localparam int LIT_WORDS   = ceil_div(LIT_W, DW),
  localparam int CLAIM_WORDS = ceil_div(N_PT, DW)
) (
  input  logic                           clk,
  input  logic                           gsr,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DW-1:0]                  wdata,
  output logic [N_PT-1:0][LIT_W-1:0]     lit_mask,
  output logic [N_CELL-1:0][N_PT-1:0]    claim,
  output cell_mode_t [N_CELL-1:0]        mode
);

  logic [N_PT-1:0][LIT_WORDS*DW-1:0]     lit_q;
  logic [N_CELL-1:0][CLAIM_WORDS*DW-1:0] claim_q;
  cfg_region_e                           region;
  logic [IDX_W-1:0]                      idx;
  logic [WORD_W-1:0]                     word;

  assign region = cfg_region_e'(addr[ADDR_W-1 -: 2]);
  assign idx    = addr[WORD_W +: IDX_W];
  assign word   = addr[WORD_W-1:0];

  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) begin
      lit_q   <= '0;
      claim_q <= '0;
      mode    <= '0;
    end else if (we) begin
      for (int t = 0; t < N_PT; t++)
        for (int w = 0; w < LIT_WORDS; w++)
          if (region == RG_TERM && idx == IDX_W'(t) && word == WORD_W'(w))
            lit_q[t][w*DW +: DW] <= wdata;
      for (int c = 0; c < N_CELL; c++) begin
        for (int w = 0; w < CLAIM_WORDS; w++)
          if (region == RG_CLAIM && idx == IDX_W'(c) && word == WORD_W'(w))
            claim_q[c][w*DW +: DW] <= wdata;
        if (region == RG_MODE && idx == IDX_W'(c))
          mode[c] <= cell_mode_t'(wdata[3:0]);
      end
    end
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_lit
    assign lit_mask[t] = lit_q[t][LIT_W-1:0];
  end
  for (genvar c = 0; c < N_CELL; c++) begin : g_claim
    assign claim[c] = claim_q[c][N_PT-1:0];
  end

endmodule

// File: rtl/sop_and_array.sv
module sop_and_array #(
  parameter int N_IN = 54,
  parameter int N_PT = 90,
  localparam int LIT_W = 2 * N_IN
) (
  input  logic [N_IN-1:0]             din,
  input  logic [N_PT-1:0][LIT_W-1:0]  lit_mask,
  output logic [N_PT-1:0]             pterm
);

  // even literal = true input, odd literal = complemented input
  function automatic logic [LIT_W-1:0] make_lits(logic [N_IN-1:0] x);
    logic [LIT_W-1:0] l;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i]   = x[i];
      l[2*i+1] = ~x[i];
    end
    return l;
  endfunction

  // unselected literals are forced to 1, so an empty mask yields 1
  function automatic logic eval_term(logic [LIT_W-1:0] mask, logic [LIT_W-1:0] lits);
    return &(lits | ~mask);
  endfunction

  logic [LIT_W-1:0] lits;
  assign lits = make_lits(din);

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign pterm[t] = eval_term(lit_mask[t], lits);
  end

endmodule

// File: rtl/sop_allocator.sv
module sop_allocator #(
  parameter int N_PT   = 90,
  parameter int N_CELL = 18
) (
  input  logic [N_CELL-1:0][N_PT-1:0] claim,
  output logic [N_CELL-1:0][N_PT-1:0] grant,
  output logic [N_PT-1:0]             term_conflict,
  output logic                        err
);

  logic [N_PT-1:0] taken;

  // lowest-numbered claimant wins each term
  always_comb begin
    taken         = '0;
    term_conflict = '0;
    grant         = '0;
    for (int t = 0; t < N_PT; t++) begin
      for (int c = 0; c < N_CELL; c++) begin
        grant[c][t] = claim[c][t] & ~taken[t];
        if (claim[c][t] && taken[t]) term_conflict[t] = 1'b1;
        taken[t] = taken[t] | claim[c][t];
      end
    end
  end

  assign err = |term_conflict;

endmodule

// File: rtl/sop_cell.sv
module sop_cell
  import sop_pkg::*;
#(
  parameter int N_PT = 90
) (
  input  logic            clk,
  input  logic            gsr,
  input  logic            goe,
  input  logic [N_PT-1:0] pterm,
  input  logic [N_PT-1:0] grant_row,
  input  cell_mode_t      mode,
  output logic            val,
  output logic            dout,
  output logic            doe
);

  logic sum;
  logic q;

  assign sum = |(pterm & grant_row);
  assign val = sum ^ mode.invert;

  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) q <= 1'b0;
    else     q <= val;
  end

  assign dout = mode.registered ? q : val;
  assign doe  = oe_value(mode.oe, goe);

endmodule

// File: rtl/sop_block.sv
module sop_block
  import sop_pkg::*;
#(
  parameter int N_IN   = 54,
  parameter int N_PT   = 90,
  parameter int N_CELL = 18,
  parameter int DW     = 36,
  localparam int LIT_W  = 2 * N_IN,
  localparam int IDX_W  = idx_bits(N_PT, N_CELL),
  localparam int WORD_W = word_bits(N_IN, N_PT, DW),
  localparam int ADDR_W = 2 + IDX_W + WORD_W
) (
  input  logic              clk,
  input  logic              gsr,
  input  logic              goe,
  input  logic [N_IN-1:0]   din,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [N_CELL-1:0] dout,
  output logic [N_CELL-1:0] doe,
  output logic              cfg_err
);

  logic [N_PT-1:0][LIT_W-1:0]  lit_mask;
  logic [N_CELL-1:0][N_PT-1:0] claim;
  logic [N_CELL-1:0][N_PT-1:0] grant;
  cell_mode_t [N_CELL-1:0]     cell_mode;
  logic [N_PT-1:0]             pterm;
  logic [N_PT-1:0]             term_conflict;
  logic [N_CELL-1:0]           cell_val;

  sop_cfg_store #(
    .N_IN(N_IN), .N_PT(N_PT), .N_CELL(N_CELL), .DW(DW),
    .IDX_W(IDX_W), .WORD_W(WORD_W)
  ) u_cfg (
    .clk(clk), .gsr(gsr), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lit_mask(lit_mask), .claim(claim), .mode(cell_mode)
  );

  sop_and_array #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
    .din(din), .lit_mask(lit_mask), .pterm(pterm)
  );

  sop_allocator #(.N_PT(N_PT), .N_CELL(N_CELL)) u_alloc (
    .claim(claim), .grant(grant), .term_conflict(term_conflict), .err(cfg_err)
  );

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    sop_cell #(.N_PT(N_PT)) u_cell (
      .clk(clk), .gsr(gsr), .goe(goe), .pterm(pterm), .grant_row(grant[c]),
      .mode(cell_mode[c]), .val(cell_val[c]), .dout(dout[c]), .doe(doe[c])
    );
  end

endmodule

// File: rtl/sop_block_chk.sv
module sop_block_chk
  import sop_pkg::*;
#(
  parameter int N_IN   = 54,
  parameter int N_PT   = 90,
  parameter int N_CELL = 18,
  parameter int DW     = 36,
  localparam int IDX_W  = idx_bits(N_PT, N_CELL),
  localparam int WORD_W = word_bits(N_IN, N_PT, DW),
  localparam int ADDR_W = 2 + IDX_W + WORD_W
) (
  input logic                        clk,
  input logic                        gsr,
  input logic                        cfg_we,
  input logic [ADDR_W-1:0]           cfg_addr,
  input logic [DW-1:0]               cfg_wdata,
  input logic [N_CELL-1:0]           dout,
  input logic [N_CELL-1:0]           doe,
  input logic                        cfg_err,
  input cell_mode_t [N_CELL-1:0]     cell_mode,
  input logic [N_CELL-1:0][N_PT-1:0] claim,
  input logic [N_CELL-1:0][N_PT-1:0] grant,
  input logic [N_CELL-1:0]           cell_val
);

  logic past_ok;
  always_ff @(posedge clk or posedge gsr) begin
    if (gsr) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  logic [N_PT-1:0][N_CELL-1:0] grant_col;
  always_comb begin
    for (int t = 0; t < N_PT; t++)
      for (int c = 0; c < N_CELL; c++)
        grant_col[t][c] = grant[c][t];
  end

  for (genvar t = 0; t < N_PT; t++) begin : g_term_chk
    p_single_owner_r5: assert property (@(posedge clk) disable iff (gsr)
      $onehot0(grant_col[t]));
  end

  p_claims_honoured_r5: assert property (@(posedge clk) disable iff (gsr)
    !cfg_err |-> (grant == claim));

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell_chk
    p_reg_delay_r7: assert property (@(posedge clk) disable iff (gsr)
      past_ok && cell_mode[c].registered && $past(cell_mode[c].registered)
      |-> dout[c] == $past(cell_val[c]));

    p_oe_off_r9: assert property (@(posedge clk) disable iff (gsr)
      doe[c] |-> cell_mode[c].oe != OE_OFF);

    p_mode_write_r10: assert property (@(posedge clk) disable iff (gsr)
      cfg_we && cfg_addr[ADDR_W-1 -: 2] == RG_MODE
      && cfg_addr[WORD_W +: IDX_W] == IDX_W'(c)
      |=> cell_mode[c] == cell_mode_t'($past(cfg_wdata[3:0])));
  end

endmodule

bind sop_block sop_block_chk #(
  .N_IN(N_IN), .N_PT(N_PT), .N_CELL(N_CELL), .DW(DW)
) u_chk (
  .clk(clk), .gsr(gsr), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .dout(dout), .doe(doe), .cfg_err(cfg_err),
  .cell_mode(cell_mode), .claim(claim), .grant(grant), .cell_val(cell_val)
);

// File: tb/sop_block_bench.sv
module sop_block_bench;

  localparam int N_IN   = 54;
  localparam int N_PT   = 90;
  localparam int N_CELL = 18;
  localparam int DW     = 36;

  logic              clk = 1'b0;
  logic              gsr = 1'b1;
  logic              goe = 1'b0;
  logic [N_IN-1:0]   din = '0;
  logic              cfg_we = 1'b0;
  logic [10:0]       cfg_addr = '0;
  logic [DW-1:0]     cfg_wdata = '0;
  logic [N_CELL-1:0] dout;
  logic [N_CELL-1:0] doe;
  logic              cfg_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  sop_block u_sop_block (
    .clk(clk), .gsr(gsr), .goe(goe), .din(din), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .dout(dout), .doe(doe),
    .cfg_err(cfg_err)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] rg, int idx, int word, logic [DW-1:0] data);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = {rg, 7'(idx), 2'(word)};
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic wr_lits(int t, logic [107:0] m);
    for (int w = 0; w < 3; w++) wr(2'd0, t, w, m[w*DW +: DW]);
  endtask

  task automatic wr_claim(int c, logic [89:0] m);
    logic [107:0] p;
    p = {18'd0, m};
    for (int w = 0; w < 3; w++) wr(2'd1, c, w, p[w*DW +: DW]);
  endtask

  task automatic wr_mode(int c, logic [3:0] m);
    wr(2'd2, c, 0, {32'd0, m});
  endtask

  task automatic do_reset();
    @(negedge clk);
    gsr = 1'b1;
    din = '0;
    @(negedge clk);
    gsr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R12 dout", 32'(dout), 0);
    check("R12 doe", 32'(doe), 0);
    check("R12 cfg_err", 32'(cfg_err), 0);
  endtask

  task automatic t_literals();
    do_reset();
    wr_lits(0, 108'b1001);          // in0 true AND in1 complement
    wr_lits(1, 108'b11 << 4);       // in2 true AND in2 complement
    wr_claim(0, 90'd1);
    wr_claim(1, 90'd2);
    wr_mode(0, 4'b0100);
    wr_mode(1, 4'b0100);
    din = '0; din[0] = 1'b1; #1;
    check("R1 in0 & ~in1", 32'(dout[0]), 1);
    check("R9 oe on", 32'(doe[0]), 1);
    din[1] = 1'b1; #1;
    check("R1 in1 set kills term", 32'(dout[0]), 0);
    din[2] = 1'b1; #1;
    check("R1 both polarities in2=1", 32'(dout[1]), 0);
    din[2] = 1'b0; #1;
    check("R1 both polarities in2=0", 32'(dout[1]), 0);
  endtask

  task automatic t_empty_invert();
    do_reset();
    wr_claim(2, 90'd1 << 5);        // term 5, mask left empty
    wr_mode(2, 4'b0100);
    wr_mode(3, 4'b0100);
    #1;
    check("R2 empty term is 1", 32'(dout[2]), 1);
    check("R3 no terms gives 0", 32'(dout[3]), 0);
    wr_mode(2, 4'b0110);
    wr_mode(3, 4'b0110);
    #1;
    check("R6 invert of 1", 32'(dout[2]), 0);
    check("R6 invert of empty sum", 32'(dout[3]), 1);
  endtask

  task automatic t_or();
    logic [107:0] m;
    do_reset();
    wr_lits(10, 108'd1 << 10);      // in5 true
    m = '0; m[106] = 1'b1;          // in53 true
    wr_lits(11, m);
    wr_claim(4, 90'b11 << 10);
    wr_mode(4, 4'b0100);
    din = '0; #1;
    check("R3 or none", 32'(dout[4]), 0);
    din[5] = 1'b1; #1;
    check("R3 or first", 32'(dout[4]), 1);
    din[5] = 1'b0; din[53] = 1'b1; #1;
    check("R3 or second", 32'(dout[4]), 1);
  endtask

  task automatic t_all_terms();
    do_reset();
    for (int t = 0; t < N_PT - 1; t++) wr(2'd0, t, 0, 36'd1);
    wr(2'd0, N_PT - 1, 0, 36'd4);
    wr_claim(17, '1);
    wr_mode(17, 4'b0100);
    din = '0; #1;
    check("R4 all terms low", 32'(dout[17]), 0);
    check("R5 single claimant no err", 32'(cfg_err), 0);
    din[1] = 1'b1; #1;
    check("R4 last term alone", 32'(dout[17]), 1);
    din[1] = 1'b0; din[0] = 1'b1; #1;
    check("R4 first terms", 32'(dout[17]), 1);
  endtask

  task automatic t_conflict();
    do_reset();
    wr_claim(6, 90'd1 << 20);
    wr_claim(9, 90'd1 << 20);
    wr_mode(6, 4'b0100);
    wr_mode(9, 4'b0100);
    #1;
    check("R5 err raised", 32'(cfg_err), 1);
    check("R5 low cell wins", 32'(dout[6]), 1);
    check("R5 high cell loses", 32'(dout[9]), 0);
    wr_claim(6, '0);
    #1;
    check("R5 err clears", 32'(cfg_err), 0);
    check("R5 term passes on", 32'(dout[9]), 1);
    check("R5 released cell", 32'(dout[6]), 0);
  endtask

  task automatic t_registered();
    do_reset();
    wr_lits(30, 108'd1 << 14);      // in7 true
    wr_claim(7, 90'd1 << 30);
    wr_mode(7, 4'b0101);
    @(negedge clk);
    din[7] = 1'b1; #1;
    check("R7 holds before edge", 32'(dout[7]), 0);
    @(negedge clk); #1;
    check("R7 captured at edge", 32'(dout[7]), 1);
    din[7] = 1'b0; #1;
    check("R7 holds after input drop", 32'(dout[7]), 1);
    @(negedge clk); #1;
    check("R7 drops at edge", 32'(dout[7]), 0);
    din[7] = 1'b1;
    @(negedge clk); #1;
    check("R7 high again", 32'(dout[7]), 1);
    #3 gsr = 1'b1; #1;
    check("R8 async clear dout", 32'(dout[7]), 0);
    check("R8 async clear doe", 32'(doe), 0);
    @(negedge clk);
    gsr = 1'b0;
    @(negedge clk); #1;
    check("R8 config gone after release", 32'(dout[7]), 0);
    din = '0;
  endtask

  task automatic t_oe();
    do_reset();
    #1;
    check("R9 oe off", 32'(doe[8]), 0);
    wr_mode(8, 4'b1000);
    goe = 1'b1; #1;
    check("R9 global oe 1", 32'(doe[8]), 1);
    goe = 1'b0; #1;
    check("R9 global oe 0", 32'(doe[8]), 0);
    wr_mode(8, 4'b1100);
    #1;
    check("R9 inverted global", 32'(doe[8]), 1);
    goe = 1'b1; #1;
    check("R9 inverted global high", 32'(doe[8]), 0);
    goe = 1'b0;
  endtask

  task automatic t_cfg_port();
    do_reset();
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'd2, 7'd10, 2'd0}; cfg_wdata = 36'h4;
    #1;
    check("R10 no effect before edge", 32'(doe[10]), 0);
    @(negedge clk);
    cfg_we = 1'b0; #1;
    check("R10 effect after edge", 32'(doe[10]), 1);
    wr(2'd2, 18, 0, 36'hF);
    wr(2'd3, 0, 0, 36'hF);
    wr(2'd1, 0, 3, '1);
    wr_mode(0, 4'b0100);
    #1;
    check("R11 bad writes leave doe", 32'(doe), 32'h401);
    check("R11 word 3 claim ignored", 32'(dout[0]), 0);
  endtask

  initial begin
    #4000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_literals();
    t_empty_invert();
    t_or();
    t_all_terms();
    t_conflict();
    t_registered();
    t_oe();
    t_cfg_port();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule